// File: doc/BRIEF.md
# Pipelined Burst Memory Cycle Controller

This block sits in front of a synchronous burst memory with a register-to-register read pipeline. On every rising clock edge it looks at two active-low address strobes (one meant for a processor, one for a memory controller), three chip enables, a global write enable, a byte-write qualifier with per-byte enables, the burst advance input and the output enable. From these it decides what happens on that edge. A new read starts, a new write starts, the current burst continues or holds, or the device deselects. A small behavioural array, one lane per byte, stands in for the storage.

The controller is a three-state machine. The states are `ST_DESEL` (reset state, no burst open), `ST_READ` (burst open, the read pipeline is fed) and `ST_WRITE` (burst open, write data is taken in and the output drivers are off). The transitions are named after the decoded edge command:
- *start-read* goes to `ST_READ`.
- *start-write* goes to `ST_WRITE`.
- *deselect* goes to `ST_DESEL`.
- *continue* leaves `ST_DESEL` unchanged. From either open state it goes to `ST_WRITE` when a byte write is requested on that edge, and to `ST_READ` otherwise.

Read data leave through a data-out register one edge after the address was registered. The data-bus driver enable stays on for one extra edge after a deselect, which is double-cycle deselect timing.

Top module: `sram_burst_ctrl`

## Requirements
- R1: While reset is asserted the data-bus driver enable `dq_oe_o` is 0, and after reset the controller is in `ST_DESEL`.
- R2: An edge with `adsp_n_i` low, `ce0_n_i` low and the other two enables active starts a read at `addr_i`. This holds whatever `adsc_n_i`, `gw_n_i`, `bwe_n_i` and `bw_n_i` are, and `adv_n_i` is not used on that edge.
- R3: An edge where the processor strobe is not in effect, with `adsc_n_i` low and all enables active, starts a cycle at `addr_i`. It is a write when `gw_n_i` is low, or when `bwe_n_i` is low with at least one `bw_n_i` bit low. Otherwise it is a read.
- R4: When `ce0_n_i` is high, a low `adsp_n_i` has no effect. With `adsc_n_i` and `adv_n_i` high and no write requested, the burst address and the read data stay as they were.
- R5: An effective strobe sampled while any enable is inactive (`ce0_n_i` high, `ce1_i` low or `ce2_n_i` high) moves the controller to `ST_DESEL`.
- R6: Data for an address registered on edge k appear on `dq_rd_o`, with `dq_oe_o` high when `oe_n_i` is low, after edge k+1.
- R7: With both strobes high and `adv_n_i` low, the two low address bits step through the burst while the upper bits stay fixed. When `linear_i` is 1 the order is start+n modulo 4. When `linear_i` is 0 the order is start XOR n.
- R8: A low `gw_n_i` writes all bytes. Otherwise, with `bwe_n_i` low, byte i (bits 8i+7..8i) is written exactly when `bw_n_i[i]` is low.
- R9: On a continue edge of an open burst, a write request writes `dq_wr_i` to the burst address after any advance on that edge. `dq_oe_o` is 0 while the controller is in `ST_WRITE`.
- R10: After a deselect is registered on edge j that ends a read, `dq_oe_o` stays high (if `oe_n_i` is low) until edge j+2. The last read data stay on `dq_rd_o`.
- R11: `dq_oe_o` is 1 only when `oe_n_i` is low and a read result, or its one-edge deselect extension, is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Address sampled at cycle start |
| adsp_n_i | input | 1 | Processor address strobe, active low |
| adsc_n_i | input | 1 | Controller address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| ce0_n_i | input | 1 | Master chip enable, active low |
| ce1_i | input | 1 | Chip enable, active high |
| ce2_n_i | input | 1 | Chip enable, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write qualifier, active low |
| bw_n_i | input | NB | Per-byte write enables, active low |
| oe_n_i | input | 1 | Output enable, active low |
| linear_i | input | 1 | 1: linear burst order, 0: interleaved |
| dq_wr_i | input | DW | Write data from the bus |
| dq_rd_o | output | DW | Read data from the data-out register |
| dq_oe_o | output | 1 | Driver enable of the bidirectional bus |

## Verification
A wrong state register shows up at the ports within one or two edges.
- A burst falsely left open keeps `dq_oe_o` high past the two-edge deselect window.
- A missed start returns data from the previous burst address on the edge after the strobe.
- A wrong burst order or a skipped advance gives a wrong word on the following edge.
- A lost write gives a wrong word on the first read-back.

The bench holds a behavioural model and compares the driver enable every cycle, and the read data whenever the bus is driven. It also runs directed sequences for each ordering, blocking and deselect case.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_state_e;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_DESEL    = 3'd1,
        CMD_RD_START = 3'd2,
        CMD_WR_START = 3'd3
    } edge_cmd_e;

endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
    import sram_burst_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic            adsp_n_i,
    input  logic            adsc_n_i,
    input  logic            ce0_n_i,
    input  logic            ce1_i,
    input  logic            ce2_n_i,
    input  logic            gw_n_i,
    input  logic            bwe_n_i,
    input  logic [NB-1:0]   bw_n_i,
    output edge_cmd_e       cmd_o,
    output logic [NB-1:0]   byte_wr_o
);

    logic proc_go;
    logic enables_ok;

    // the master enable gates the processor strobe only
    assign proc_go    = !adsp_n_i && !ce0_n_i;
    assign enables_ok = !ce0_n_i && ce1_i && !ce2_n_i;

    always_comb begin
        if (!gw_n_i) begin
            byte_wr_o = {NB{1'b1}};
        end else if (!bwe_n_i) begin
            byte_wr_o = ~bw_n_i;
        end else begin
            byte_wr_o = '0;
        end
    end

    always_comb begin
        if (proc_go) begin
            cmd_o = enables_ok ? CMD_RD_START : CMD_DESEL;
        end else if (!adsc_n_i) begin
            if (!enables_ok) begin
                cmd_o = CMD_DESEL;
            end else if (|byte_wr_o) begin
                cmd_o = CMD_WR_START;
            end else begin
                cmd_o = CMD_RD_START;
            end
        end else begin
            cmd_o = CMD_NONE;
        end
    end

endmodule

// File: rtl/sbc_burst_addr.sv
module sbc_burst_addr #(
    parameter int AW = 8,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          adv_i,
    input  logic          linear_i,
    output logic [AW-1:0] cur_addr_o,
    output logic [AW-1:0] next_addr_o
);

    localparam int HW = AW - BB;
    localparam logic [BB-1:0] STEP = 1;

    logic [HW-1:0] hi_q;
    logic [BB-1:0] base_q;
    logic [BB-1:0] cnt_q;
    logic [BB-1:0] cnt_nx;

    assign cnt_nx = cnt_q + STEP;

    function automatic logic [BB-1:0] lane_order(input logic [BB-1:0] b,
                                                 input logic [BB-1:0] n,
                                                 input logic          lin);
        return lin ? (b + n) : (b ^ n);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            hi_q   <= load_addr_i[AW-1:BB];
            base_q <= load_addr_i[BB-1:0];
            cnt_q  <= '0;
        end else if (adv_i) begin
            cnt_q  <= cnt_nx;
        end
    end

    assign cur_addr_o  = {hi_q, lane_order(base_q, cnt_q,  linear_i)};
    assign next_addr_o = {hi_q, lane_order(base_q, cnt_nx, linear_i)};

endmodule

// File: rtl/sbc_mem.sv
module sbc_mem #(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic [NB-1:0] we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;
    localparam int BW    = DW / NB;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g]) begin
                lane_q[waddr_i] <= wdata_i[g*BW +: BW];
            end
        end

        assign rdata_o[g*BW +: BW] = lane_q[raddr_i];
    end

endmodule

// File: rtl/sbc_read_pipe.sv
module sbc_read_pipe #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_active_i,
    input  logic          desel_i,
    input  logic          wr_active_i,
    input  logic          oe_n_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] dq_o,
    output logic          drive_o
);

    logic          drv_q;
    logic          hold_q;
    logic [DW-1:0] dout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q  <= 1'b0;
            hold_q <= 1'b0;
            dout_q <= '0;
        end else begin
            drv_q  <= rd_active_i;
            // one extra edge of drive when a read burst is deselected
            hold_q <= drv_q && desel_i;
            if (rd_active_i) begin
                dout_q <= rdata_i;
            end
        end
    end

    assign dq_o    = dout_q;
    assign drive_o = !oe_n_i && (drv_q || hold_q) && !wr_active_i;

endmodule

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sram_burst_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int NB = 4,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          adsp_n_i,
    input  logic          adsc_n_i,
    input  logic          adv_n_i,
    input  logic          ce0_n_i,
    input  logic          ce1_i,
    input  logic          ce2_n_i,
    input  logic          gw_n_i,
    input  logic          bwe_n_i,
    input  logic [NB-1:0] bw_n_i,
    input  logic          oe_n_i,
    input  logic          linear_i,
    input  logic [DW-1:0] dq_wr_i,
    output logic [DW-1:0] dq_rd_o,
    output logic          dq_oe_o
);

    cyc_state_e    state_q;
    cyc_state_e    state_d;
    edge_cmd_e     cmd;
    logic [NB-1:0] byte_wr;
    logic          addr_load;
    logic          addr_adv;
    logic [NB-1:0] mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] next_addr;
    logic [DW-1:0] mem_rdata;

    sbc_cmd_decode #(.NB(NB)) u_dec (
        .adsp_n_i  (adsp_n_i),
        .adsc_n_i  (adsc_n_i),
        .ce0_n_i   (ce0_n_i),
        .ce1_i     (ce1_i),
        .ce2_n_i   (ce2_n_i),
        .gw_n_i    (gw_n_i),
        .bwe_n_i   (bwe_n_i),
        .bw_n_i    (bw_n_i),
        .cmd_o     (cmd),
        .byte_wr_o (byte_wr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_DESEL:    state_d = ST_DESEL;
            CMD_RD_START: state_d = ST_READ;
            CMD_WR_START: state_d = ST_WRITE;
            CMD_NONE: begin
                unique case (state_q)
                    ST_DESEL: state_d = ST_DESEL;
                    ST_READ,
                    ST_WRITE: state_d = (|byte_wr) ? ST_WRITE : ST_READ;
                    default:  state_d = ST_DESEL;
                endcase
            end
            default: state_d = ST_DESEL;
        endcase
    end

    // per-edge actions
    always_comb begin
        addr_load = 1'b0;
        addr_adv  = 1'b0;
        mem_we    = '0;
        mem_waddr = cur_addr;
        unique case (cmd)
            CMD_RD_START: addr_load = 1'b1;
            CMD_WR_START: begin
                addr_load = 1'b1;
                mem_we    = byte_wr;
                mem_waddr = addr_i;
            end
            CMD_NONE: begin
                if (state_q != ST_DESEL) begin
                    addr_adv  = !adv_n_i;
                    mem_we    = byte_wr;
                    mem_waddr = addr_adv ? next_addr : cur_addr;
                end
            end
            default: ;
        endcase
    end

    sbc_burst_addr #(.AW(AW), .BB(BB)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (addr_load),
        .load_addr_i (addr_i),
        .adv_i       (addr_adv),
        .linear_i    (linear_i),
        .cur_addr_o  (cur_addr),
        .next_addr_o (next_addr)
    );

    sbc_mem #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
        .clk     (clk),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (dq_wr_i),
        .raddr_i (cur_addr),
        .rdata_o (mem_rdata)
    );

    sbc_read_pipe #(.DW(DW)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_active_i (state_q == ST_READ),
        .desel_i     (state_q == ST_DESEL),
        .wr_active_i (state_q == ST_WRITE),
        .oe_n_i      (oe_n_i),
        .rdata_i     (mem_rdata),
        .dq_o        (dq_rd_o),
        .drive_o     (dq_oe_o)
    );

endmodule

// File: rtl/sram_burst_ctrl_chk.sv
module sram_burst_ctrl_chk
    import sram_burst_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adsp_n_i,
    input logic          adsc_n_i,
    input logic          adv_n_i,
    input logic          ce0_n_i,
    input logic          ce1_i,
    input logic          ce2_n_i,
    input logic          gw_n_i,
    input logic          bwe_n_i,
    input logic          oe_n_i,
    input logic          dq_oe_o,
    input cyc_state_e    state_q,
    input logic [AW-1:0] cur_addr
);

    // R1: bus released during reset
    always_comb begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!dq_oe_o);
        end
    end

    // R11: never drive with output enable off
    a_r11_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !dq_oe_o);

    // R6: a processor read start shows data two edges later
    a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n_i && !ce0_n_i && ce1_i && !ce2_n_i)
        |-> ##2 (oe_n_i || state_q == ST_WRITE || dq_oe_o));

    // R5: controller strobe with an inactive enable deselects
    a_r5_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n_i && !adsc_n_i && !ce1_i) |=> state_q == ST_DESEL);

    // R4: blocked processor strobe changes neither address nor state
    a_r4_ce0_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n_i && ce0_n_i && adsc_n_i && adv_n_i && gw_n_i && bwe_n_i
         && state_q != ST_WRITE)
        |=> (cur_addr == $past(cur_addr) && state_q == $past(state_q)));

    // R9: a burst write turns the drivers off
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n_i && adsc_n_i && !gw_n_i && state_q != ST_DESEL) |=> !dq_oe_o);

    // R10: drive persists one extra edge after a read is deselected
    a_r10_double_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESEL && $past(state_q) == ST_READ)
        |=> (oe_n_i || state_q == ST_WRITE || dq_oe_o));

endmodule

bind sram_burst_ctrl sram_burst_ctrl_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adsp_n_i (adsp_n_i),
    .adsc_n_i (adsc_n_i),
    .adv_n_i  (adv_n_i),
    .ce0_n_i  (ce0_n_i),
    .ce1_i    (ce1_i),
    .ce2_n_i  (ce2_n_i),
    .gw_n_i   (gw_n_i),
    .bwe_n_i  (bwe_n_i),
    .oe_n_i   (oe_n_i),
    .dq_oe_o  (dq_oe_o),
    .state_q  (state_q),
    .cur_addr (cur_addr)
);

// File: tb/sram_burst_ctrl_bench.sv
module sram_burst_ctrl_bench;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic        ce0_n = 1'b0, ce1 = 1'b1, ce2_n = 1'b0;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic        oe_n = 1'b1, linear = 1'b0;
    logic [31:0] dq_wr = '0;
    logic [31:0] dq_rd;
    logic        dq_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    sram_burst_ctrl u_sram_burst_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_i(addr),
        .adsp_n_i(adsp_n), .adsc_n_i(adsc_n), .adv_n_i(adv_n),
        .ce0_n_i(ce0_n), .ce1_i(ce1), .ce2_n_i(ce2_n),
        .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bw_n_i(bw_n),
        .oe_n_i(oe_n), .linear_i(linear), .dq_wr_i(dq_wr),
        .dq_rd_o(dq_rd), .dq_oe_o(dq_oe)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st;   // 0 idle, 1 reading, 2 writing
    int          m_hi, m_base, m_cnt;
    bit          m_drv, m_hold, m_dk;
    logic [31:0] m_dout;
    logic [31:0] m_mem [int];

    function automatic int m_addr(int n);
        int low;
        low = linear ? ((m_base + n) % 4) : ((m_base ^ n) % 4);
        return m_hi * 4 + low;
    endfunction

    task automatic m_write(int a, logic [3:0] msk);
        logic [31:0] w;
        w = m_mem.exists(a) ? m_mem[a] : 32'hxxxx_xxxx;
        for (int b = 0; b < 4; b++) begin
            if (msk[b]) w[b*8 +: 8] = dq_wr[b*8 +: 8];
        end
        m_mem[a] = w;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_drv = 0; m_hold = 0; m_dk = 0;
            m_hi = 0; m_base = 0; m_cnt = 0; m_dout = '0;
        end else begin
            bit          ok_en;
            logic [3:0]  msk;
            bit          nd;
            bit          nh;
            nh = m_drv && (m_st == 0);
            nd = (m_st == 1);
            if (nd) begin
                int a;
                a = m_addr(m_cnt);
                m_dk   = m_mem.exists(a) && !$isunknown(m_mem[a]);
                m_dout = m_dk ? m_mem[a] : 32'h0;
            end
            ok_en = !ce0_n && ce1 && !ce2_n;
            msk = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
            if (!adsp_n && !ce0_n) begin
                if (ok_en) begin
                    m_hi = addr / 4; m_base = addr % 4; m_cnt = 0; m_st = 1;
                end else m_st = 0;
            end else if (!adsc_n) begin
                if (ok_en) begin
                    m_hi = addr / 4; m_base = addr % 4; m_cnt = 0;
                    if (msk != 0) m_write(int'(addr), msk);
                    m_st = (msk != 0) ? 2 : 1;
                end else m_st = 0;
            end else if (m_st != 0) begin
                if (!adv_n) m_cnt = (m_cnt + 1) % 4;
                if (msk != 0) m_write(m_addr(m_cnt), msk);
                m_st = (msk != 0) ? 2 : 1;
            end
            m_drv = nd; m_hold = nh;
        end
        #2;
        if (!done) begin
            bit ed;
            ed = !oe_n && (m_drv || m_hold) && (m_st != 2);
            chk({31'b0, dq_oe}, {31'b0, ed}, "R11 R10 driver enable vs model");
            if (ed && m_dk) chk(dq_rd, m_dout, "R6 read data vs model");
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic go();
        @(posedge clk);
        #3;
    endtask

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
        ce0_n = 0; ce1 = 1; ce2_n = 0;
    endtask

    task automatic rd_single(input logic [7:0] a, output logic [31:0] d, output logic oe);
        idle(); oe_n = 0; adsc_n = 0; bwe_n = 0; addr = a;
        go();
        idle();
        go();
        d = dq_rd; oe = dq_oe;
    endtask

    task automatic wr_burst(input logic [7:0] a, input logic lin, input logic [31:0] d0,
                            input logic [31:0] d1, input logic [31:0] d2, input logic [31:0] d3);
        idle(); oe_n = 1; linear = lin; adsc_n = 0; gw_n = 0; addr = a; dq_wr = d0;
        go();
        adsc_n = 1; adv_n = 0; dq_wr = d1; go();
        dq_wr = d2; go();
        dq_wr = d3; go();
        idle(); go();
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        o;
        repeat (3) go();
        chk({31'b0, dq_oe}, 32'h0, "R1 no drive in reset");
        @(negedge clk); rst_n = 1;
        go();
        chk({31'b0, dq_oe}, 32'h0, "R1 idle after reset");

        // R7 interleaved write burst from 0x11: 11,10,13,12
        wr_burst(8'h11, 1'b0, 32'hA000_0000, 32'hA000_0001, 32'hA000_0002, 32'hA000_0003);

        // R2 processor read at 0x10; ADV, ADSC and writes ignored on that edge
        idle(); oe_n = 0; linear = 0; adsp_n = 0; adsc_n = 0; gw_n = 0; adv_n = 0;
        addr = 8'h10; dq_wr = 32'hDEAD_0000;
        go();
        idle(); adv_n = 0;
        go();
        chk(dq_rd, 32'hA000_0001, "R2 R6 first word at start address");
        chk({31'b0, dq_oe}, 32'h1, "R6 bus driven");
        go();
        chk(dq_rd, 32'hA000_0000, "R7 interleaved second word");
        go();
        chk(dq_rd, 32'hA000_0003, "R7 interleaved third word");
        go();
        chk(dq_rd, 32'hA000_0002, "R7 interleaved fourth word");

        // R4 blocked processor strobe: address wrapped to 0x10 and stays
        idle(); ce0_n = 1; adsp_n = 0; addr = 8'h33;
        go(); go();
        chk(dq_rd, 32'hA000_0001, "R4 address unchanged");
        chk({31'b0, dq_oe}, 32'h1, "R4 no deselect");

        // R7 linear write burst from 0x22: 22,23,20,21; R3 reads back
        wr_burst(8'h22, 1'b1, 32'hB000_0000, 32'hB000_0001, 32'hB000_0002, 32'hB000_0003);
        rd_single(8'h20, d, o); chk(d, 32'hB000_0002, "R7 linear word at 0x20");
        rd_single(8'h21, d, o); chk(d, 32'hB000_0003, "R7 linear word at 0x21");
        rd_single(8'h22, d, o); chk(d, 32'hB000_0000, "R3 controller read 0x22");
        rd_single(8'h23, d, o); chk(d, 32'hB000_0001, "R7 linear word at 0x23");

        // R8 byte writes through the controller strobe
        idle(); oe_n = 1; adsc_n = 0; gw_n = 0; addr = 8'h30; dq_wr = 32'h1122_3344; go();
        idle(); adsc_n = 0; bwe_n = 0; bw_n = 4'b1010; addr = 8'h30; dq_wr = 32'hAABB_CCDD; go();
        idle(); adsc_n = 0; bw_n = 4'b0000; addr = 8'h30; dq_wr = 32'hFFFF_FFFF; go();
        rd_single(8'h30, d, o);
        chk(d, 32'h11BB_33DD, "R8 byte lanes 0 and 2 written, R3 no-qualifier read");

        // R9 write inside an open read burst
        idle(); oe_n = 0; adsp_n = 0; addr = 8'h30; go();
        idle(); go();
        idle(); gw_n = 0; dq_wr = 32'h5555_AAAA; go();
        chk({31'b0, dq_oe}, 32'h0, "R9 drivers off during write");
        idle(); go(); go();
        chk(dq_rd, 32'h5555_AAAA, "R9 write landed at burst address");

        // R10 double-cycle deselect
        idle(); adsc_n = 0; ce1 = 0; go();
        chk({31'b0, dq_oe}, 32'h1, "R10 drive after deselect edge");
        idle(); go();
        chk({31'b0, dq_oe}, 32'h1, "R10 drive one extra edge");
        chk(dq_rd, 32'h5555_AAAA, "R10 data held");
        go();
        chk({31'b0, dq_oe}, 32'h0, "R10 released two edges after deselect");

        // R5 processor strobe with ce2 inactive deselects
        idle(); adsp_n = 0; ce2_n = 1; addr = 8'h10; go();
        idle(); go(); go();
        chk({31'b0, dq_oe}, 32'h0, "R5 no read started");

        // R11 output enable off
        idle(); adsp_n = 0; addr = 8'h10; go();
        idle(); oe_n = 1; go();
        chk({31'b0, dq_oe}, 32'h0, "R11 oe high keeps bus released");

        go();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule